// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block carries out one coprocessor instruction for the core. It supports five kinds of operation: a load into the coprocessor, a store out of it, a register move toward it, a register move out of it, and an internal data operation. It talks to the coprocessor over a three-bit phase code that it drives and a three-bit response code that comes back in the same cycle. For memory transfers it steps a post-indexed word address, and it ends every operation with exactly one of four one-cycle pulses: completed, undefined instruction, abort, or interrupted.

While the coprocessor answers busy, the block inserts one idle cycle and then looks at the pending-interrupt input. If an interrupt is pending it offers the interrupt phase and drops the instruction. Otherwise it offers the busy phase again. Before any memory access, the start address is checked against a legal upper limit, and a store is also checked against the low exception-vector region. Base-register writeback, the memory system and the interrupt controller sit outside the block.

Top module: `cp_seq`

## Requirements
- R1: After reset, `cp_phase_o` is 0 (none), `busy_o` is low and none of the four outcome pulses is high.
- R2: When `start_i` is seen while the block is idle, the next cycle offers phase 1 (first). `cp_num_o` then equals bits 11:8 of `instr_i`, and `cp_instr_o` carries the latched instruction.
- R3: A busy response (code 2) to phase 1 or phase 2 is followed by one cycle with phase 0. If no interrupt is pending in that cycle, phase 2 (busy) is offered in the cycle after it.
- R4: If `irq_pend_i` is high during the idle cycle of the busy loop, the next cycle offers phase 3 (interrupt) and pulses `intr_o`. No transfer, move or completion follows.
- R5: A can't response (code 3) to phase 1 or phase 2 pulses `undef_o` in the next cycle. For a move out of the coprocessor, `rdata_o` becomes all zero, so every condition-flag bit is clear.
- R6: Kind 0 (load) and kind 1 (store) transfer words in phase 4 (data) with `mem_req_o` high, and `mem_we_o` is high only for a store. The first word uses `addr_i`. Each increment response (code 4) adds 4 to the address and transfers one more word, and any other response ends the transfer. A load passes `mem_rdata_i` to `cp_wdata_o`, and a store passes `cp_rdata_i` to `mem_wdata_o`.
- R7: A load or store whose start address is at or above `ADDR_LIMIT` pulses `abort_o` in the cycle after start and offers no phase. The same happens for a store below `VEC_TOP`. A load below `VEC_TOP` is legal.
- R8: `mem_abort_i` high during a data-phase word pulses `abort_o` in the next cycle, and no further word is transferred.
- R9: Kind 2 (move to the coprocessor) completes with one phase-4 cycle carrying `wdata_i` on `cp_wdata_o`, followed by `done_o`.
- R10: Kind 3 (move from the coprocessor) completes with one phase-4 cycle that captures `cp_rdata_i` into `rdata_o`, then one cycle with phase 0, then `done_o`. Kind 4 (data operation) pulses `done_o` right after the accepting response.
- R11: Each outcome pulse lasts one cycle, at most one is high at a time, and the block is idle in the cycle that follows.
- R12: `start_i` asserted while an operation is in flight is ignored and does not change the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| kind_i | input | 3 | Operation kind: 0 load, 1 store, 2 move to, 3 move from, 4 data op |
| instr_i | input | INSTR_W | Coprocessor instruction word |
| addr_i | input | ADDR_W | Start address for memory transfers |
| wdata_i | input | DATA_W | Register value for a move to the coprocessor |
| irq_pend_i | input | 1 | Interrupt pending |
| mem_abort_i | input | 1 | Memory abort for the current word |
| cp_resp_i | input | 3 | Response: 1 accept, 2 busy, 3 can't, 4 increment, 5 done |
| cp_rdata_i | input | DATA_W | Data driven by the coprocessor |
| mem_rdata_i | input | DATA_W | Memory read data for the current address |
| cp_phase_o | output | 3 | Phase: 0 none, 1 first, 2 busy, 3 interrupt, 4 data |
| cp_num_o | output | NUM_W | Coprocessor number |
| cp_instr_o | output | INSTR_W | Latched instruction presented to the coprocessor |
| cp_wdata_o | output | DATA_W | Data toward the coprocessor |
| mem_req_o | output | 1 | Memory word access |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | ADDR_W | Word address |
| mem_wdata_o | output | DATA_W | Memory write data |
| rdata_o | output | DATA_W | Result of a move from the coprocessor |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | Completed pulse |
| undef_o | output | 1 | Undefined-instruction request pulse |
| abort_o | output | 1 | Abort request pulse |
| intr_o | output | 1 | Interrupted pulse |

## Verification
The embedded checks assume that the coprocessor response is a registered, stable value. They also assume that `irq_pend_i` stays high once raised until the operation ends, and that memory aborts appear only during data-phase words. The bench acts as a reactive coprocessor and memory, driving every response and abort at the falling edge from the phase it observes, so these conditions hold by construction. The start address is drawn from a small legal window, except in the directed cases that aim at the limit and the vector region.

// File: rtl/cpseq_pkg.sv
package cpseq_pkg;
   typedef enum logic [2:0] {
      PH_NONE  = 3'd0,
      PH_FIRST = 3'd1,
      PH_BUSY  = 3'd2,
      PH_INTR  = 3'd3,
      PH_DATA  = 3'd4
   } cp_phase_e;

   typedef enum logic [2:0] {
      RS_NONE   = 3'd0,
      RS_ACCEPT = 3'd1,
      RS_BUSY   = 3'd2,
      RS_CANT   = 3'd3,
      RS_INC    = 3'd4,
      RS_DONE   = 3'd5
   } cp_resp_e;

   typedef enum logic [2:0] {
      K_LOAD      = 3'd0,
      K_STORE     = 3'd1,
      K_MOVE_TO   = 3'd2,
      K_MOVE_FROM = 3'd3,
      K_DATAOP    = 3'd4
   } op_kind_e;

   typedef enum logic [3:0] {
      S_IDLE, S_OFFER, S_WAIT, S_INTR, S_UNDEF,
      S_XFER, S_CCYC, S_ICYC, S_DONE, S_ABORT
   } seq_state_e;

   function automatic logic kind_is_mem(input logic [2:0] k);
      return (k == K_LOAD) || (k == K_STORE);
   endfunction
endpackage

// File: rtl/cpseq_addr_chk.sv
module cpseq_addr_chk #(
   parameter int ADDR_W = 32,
   parameter logic [ADDR_W-1:0] LIMIT = 32'h0400_0000,
   parameter logic [ADDR_W-1:0] VEC_TOP = 32'h0000_0020,
   parameter bit VEC_CHECK = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              store_i,
   input  logic              mem_op_i,
   output logic              bad_o
);
   logic range_bad;
   logic vec_bad;

   assign range_bad = (addr_i >= LIMIT);

   generate
      if (VEC_CHECK) begin : g_vec
         assign vec_bad = store_i && (addr_i < VEC_TOP);
      end else begin : g_novec
         assign vec_bad = 1'b0 & store_i;
      end
   endgenerate

   assign bad_o = mem_op_i && (range_bad || vec_bad);
endmodule

// File: rtl/cpseq_addr_ctr.sv
module cpseq_addr_ctr #(
   parameter int ADDR_W = 32,
   parameter int STEP   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              inc_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_o <= '0;
      else if (load_i) addr_o <= base_i;
      else if (inc_i)  addr_o <= addr_o + STEP_V;
   end

   // R6
   post_index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inc_i |=> (addr_o == $past(addr_o) + STEP_V));
endmodule

// File: rtl/cpseq_fsm.sv
module cpseq_fsm
   import cpseq_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int INSTR_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [2:0]         kind_i,
   input  logic [INSTR_W-1:0] instr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic               addr_bad_i,
   input  logic               irq_pend_i,
   input  logic               mem_abort_i,
   input  logic [2:0]         cp_resp_i,
   input  logic [DATA_W-1:0]  cp_rdata_i,
   input  logic [DATA_W-1:0]  mem_rdata_i,
   output logic [2:0]         cp_phase_o,
   output logic [INSTR_W-1:0] instr_q_o,
   output logic [DATA_W-1:0]  cp_wdata_o,
   output logic               mem_req_o,
   output logic               mem_we_o,
   output logic [DATA_W-1:0]  mem_wdata_o,
   output logic [DATA_W-1:0]  rdata_o,
   output logic               ctr_load_o,
   output logic               ctr_inc_o,
   output logic               busy_o,
   output logic               done_o,
   output logic               undef_o,
   output logic               abort_o,
   output logic               intr_o
);
   seq_state_e         state;
   op_kind_e           kind_q;
   logic               first_q;
   logic [DATA_W-1:0]  wdata_q;
   logic [DATA_W-1:0]  rdata_q;
   logic [INSTR_W-1:0] instr_q;
   cp_resp_e           resp;
   logic               take;

   assign resp = cp_resp_e'(cp_resp_i);
   assign take = (state == S_IDLE) && start_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         kind_q  <= K_DATAOP;
         first_q <= 1'b0;
         wdata_q <= '0;
         rdata_q <= '0;
         instr_q <= '0;
      end else begin
         case (state)
            S_IDLE: if (start_i) begin
               kind_q  <= op_kind_e'(kind_i);
               instr_q <= instr_i;
               wdata_q <= wdata_i;
               first_q <= 1'b1;
               state   <= addr_bad_i ? S_ABORT : S_OFFER;
            end
            S_OFFER: begin
               first_q <= 1'b0;
               case (resp)
                  RS_BUSY: state <= S_WAIT;
                  RS_CANT: begin
                     state <= S_UNDEF;
                     if (kind_q == K_MOVE_FROM) rdata_q <= '0;
                  end
                  default: begin
                     if (kind_is_mem(kind_q))       state <= S_XFER;
                     else if (kind_q == K_MOVE_TO ||
                              kind_q == K_MOVE_FROM) state <= S_CCYC;
                     else                            state <= S_DONE;
                  end
               endcase
            end
            S_WAIT: state <= irq_pend_i ? S_INTR : S_OFFER;
            S_XFER: begin
               if (mem_abort_i)         state <= S_ABORT;
               else if (resp != RS_INC) state <= S_DONE;
            end
            S_CCYC: begin
               if (kind_q == K_MOVE_FROM) begin
                  rdata_q <= cp_rdata_i;
                  state   <= S_ICYC;
               end else begin
                  state <= S_DONE;
               end
            end
            S_ICYC:  state <= S_DONE;
            default: state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      cp_phase_o  = PH_NONE;
      cp_wdata_o  = '0;
      mem_req_o   = 1'b0;
      mem_we_o    = 1'b0;
      mem_wdata_o = '0;
      case (state)
         S_OFFER: cp_phase_o = first_q ? PH_FIRST : PH_BUSY;
         S_INTR:  cp_phase_o = PH_INTR;
         S_XFER: begin
            cp_phase_o = PH_DATA;
            mem_req_o  = 1'b1;
            if (kind_q == K_STORE) begin
               mem_we_o    = 1'b1;
               mem_wdata_o = cp_rdata_i;
            end else begin
               cp_wdata_o = mem_rdata_i;
            end
         end
         S_CCYC: begin
            cp_phase_o = PH_DATA;
            if (kind_q == K_MOVE_TO) cp_wdata_o = wdata_q;
         end
         default: ;
      endcase
   end

   assign instr_q_o  = instr_q;
   assign rdata_o    = rdata_q;
   assign ctr_load_o = take;
   assign ctr_inc_o  = (state == S_XFER) && (resp == RS_INC) && !mem_abort_i;
   assign busy_o     = (state != S_IDLE);
   assign done_o     = (state == S_DONE);
   assign undef_o    = (state == S_UNDEF);
   assign abort_o    = (state == S_ABORT);
   assign intr_o     = (state == S_INTR);

   // R3
   busy_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_OFFER && resp == RS_BUSY) |=> (cp_phase_o == PH_NONE));
   // R4
   intr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_phase_o == PH_INTR) |-> $past(irq_pend_i));
   // R5
   cant_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cp_phase_o == PH_FIRST || cp_phase_o == PH_BUSY) && resp == RS_CANT) |=> undef_o);
   // R8
   mem_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_abort_i) |=> (abort_o && !mem_req_o));
   // R11
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_o, undef_o, abort_o, intr_o}));
   // R12
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(kind_q));
endmodule

// File: rtl/cp_seq.sv
module cp_seq
   import cpseq_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int INSTR_W = 32,
   parameter int NUM_LSB = 8,
   parameter int NUM_W   = 4,
   parameter int WORD_BYTES = 4,
   parameter logic [ADDR_W-1:0] ADDR_LIMIT = 32'h0400_0000,
   parameter logic [ADDR_W-1:0] VEC_TOP    = 32'h0000_0020,
   parameter bit VEC_CHECK = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [2:0]         kind_i,
   input  logic [INSTR_W-1:0] instr_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic               irq_pend_i,
   input  logic               mem_abort_i,
   input  logic [2:0]         cp_resp_i,
   input  logic [DATA_W-1:0]  cp_rdata_i,
   input  logic [DATA_W-1:0]  mem_rdata_i,
   output logic [2:0]         cp_phase_o,
   output logic [NUM_W-1:0]   cp_num_o,
   output logic [INSTR_W-1:0] cp_instr_o,
   output logic [DATA_W-1:0]  cp_wdata_o,
   output logic               mem_req_o,
   output logic               mem_we_o,
   output logic [ADDR_W-1:0]  mem_addr_o,
   output logic [DATA_W-1:0]  mem_wdata_o,
   output logic [DATA_W-1:0]  rdata_o,
   output logic               busy_o,
   output logic               done_o,
   output logic               undef_o,
   output logic               abort_o,
   output logic               intr_o
);
   localparam int NUM_MSB = NUM_LSB + NUM_W - 1;

   generate
      if (ADDR_W < 8 || DATA_W < 8) begin : g_bad_width
         $error("cp_seq: address and data widths must be at least 8");
      end
      if (NUM_MSB >= INSTR_W) begin : g_bad_num
         $error("cp_seq: coprocessor number field lies outside the instruction");
      end
      if (VEC_TOP > ADDR_LIMIT) begin : g_bad_vec
         $error("cp_seq: vector region must lie below the address limit");
      end
   endgenerate

   logic addr_bad;
   logic ctr_load;
   logic ctr_inc;

   cpseq_addr_chk #(
      .ADDR_W(ADDR_W), .LIMIT(ADDR_LIMIT), .VEC_TOP(VEC_TOP), .VEC_CHECK(VEC_CHECK)
   ) u_chk (
      .addr_i   (addr_i),
      .store_i  (kind_i == K_STORE),
      .mem_op_i (kind_is_mem(kind_i)),
      .bad_o    (addr_bad)
   );

   cpseq_addr_ctr #(.ADDR_W(ADDR_W), .STEP(WORD_BYTES)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (ctr_load),
      .base_i (addr_i),
      .inc_i  (ctr_inc),
      .addr_o (mem_addr_o)
   );

   cpseq_fsm #(.DATA_W(DATA_W), .INSTR_W(INSTR_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .kind_i      (kind_i),
      .instr_i     (instr_i),
      .wdata_i     (wdata_i),
      .addr_bad_i  (addr_bad),
      .irq_pend_i  (irq_pend_i),
      .mem_abort_i (mem_abort_i),
      .cp_resp_i   (cp_resp_i),
      .cp_rdata_i  (cp_rdata_i),
      .mem_rdata_i (mem_rdata_i),
      .cp_phase_o  (cp_phase_o),
      .instr_q_o   (cp_instr_o),
      .cp_wdata_o  (cp_wdata_o),
      .mem_req_o   (mem_req_o),
      .mem_we_o    (mem_we_o),
      .mem_wdata_o (mem_wdata_o),
      .rdata_o     (rdata_o),
      .ctr_load_o  (ctr_load),
      .ctr_inc_o   (ctr_inc),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .undef_o     (undef_o),
      .abort_o     (abort_o),
      .intr_o      (intr_o)
   );

   assign cp_num_o = cp_instr_o[NUM_MSB:NUM_LSB];

   // R2
   first_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && !addr_bad) |=> (cp_phase_o == PH_FIRST));
   // R7
   bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && addr_bad) |=> (abort_o && cp_phase_o == PH_NONE));
endmodule

// File: tb/sim_cp_seq.sv
module sim_cp_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [2:0]  kind_i = '0;
   logic [31:0] instr_i = '0;
   logic [31:0] addr_i = '0;
   logic [31:0] wdata_i = '0;
   logic        irq = 1'b0;
   logic        mem_abort = 1'b0;
   logic [2:0]  cp_resp = '0;
   logic [31:0] cp_rdata_i = '0;
   logic [31:0] mem_rdata_i;
   logic [2:0]  cp_phase_o;
   logic [3:0]  cp_num_o;
   logic [31:0] cp_instr_o, cp_wdata_o, mem_addr_o, mem_wdata_o, rdata_o;
   logic        mem_req_o, mem_we_o, busy_o, done_o, undef_o, abort_o, intr_o;

   cp_seq u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
      .instr_i(instr_i), .addr_i(addr_i), .wdata_i(wdata_i),
      .irq_pend_i(irq), .mem_abort_i(mem_abort), .cp_resp_i(cp_resp),
      .cp_rdata_i(cp_rdata_i), .mem_rdata_i(mem_rdata_i),
      .cp_phase_o(cp_phase_o), .cp_num_o(cp_num_o), .cp_instr_o(cp_instr_o),
      .cp_wdata_o(cp_wdata_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
      .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .rdata_o(rdata_o),
      .busy_o(busy_o), .done_o(done_o), .undef_o(undef_o), .abort_o(abort_o),
      .intr_o(intr_o)
   );

   always #2 clk = ~clk;

   int nchk = 0, nfail = 0, cycles = 0;
   logic [31:0] mem [16];
   int c_kind, c_busy, c_final, c_irq, c_inc, c_abort;
   logic [31:0] c_addr, c_wdata, c_from, c_stpat;
   int busy_given, word_i, ab;

   function automatic int idx(input logic [31:0] a);
      return int'((a - 32'h100) >> 2) & 15;
   endfunction

   assign mem_rdata_i = mem[idx(mem_addr_o)];

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         nfail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   // reactive coprocessor and memory
   always @(negedge clk) begin
      if (ab == 1) begin
         chk(cp_phase_o == 3'd0, "R3 idle cycle after busy", 32'(cp_phase_o), 0);
         ab = 2;
      end else if (ab == 2) begin
         if (!irq) chk(cp_phase_o == 3'd2, "R3 busy phase reissued", 32'(cp_phase_o), 2);
         ab = 0;
      end
      cp_resp   = 3'd0;
      mem_abort = 1'b0;
      if (rst_n) begin
         case (cp_phase_o)
            3'd1, 3'd2: begin
               if (busy_given < c_busy) begin
                  cp_resp = 3'd2;
                  busy_given++;
                  ab = 1;
                  if (busy_given == c_irq) irq = 1'b1;
               end else begin
                  cp_resp = 3'(c_final);
               end
            end
            3'd4: begin
               if (c_kind <= 1) begin
                  chk(mem_req_o && (mem_we_o == (c_kind == 1)), "R6 request and write enable",
                      {30'd0, mem_req_o, mem_we_o}, {30'd0, 1'b1, c_kind == 1});
                  chk(mem_addr_o == c_addr + 32'(4 * word_i), "R6 post-indexed address",
                      mem_addr_o, c_addr + 32'(4 * word_i));
                  if (c_kind == 0) begin
                     chk(cp_wdata_o == mem[idx(mem_addr_o)], "R6 load word to coprocessor",
                         cp_wdata_o, mem[idx(mem_addr_o)]);
                  end else begin
                     chk(mem_wdata_o == (c_stpat ^ 32'(word_i)), "R6 store word from coprocessor",
                         mem_wdata_o, c_stpat ^ 32'(word_i));
                     mem[idx(mem_addr_o)] = mem_wdata_o;
                  end
                  if (word_i == c_abort) mem_abort = 1'b1;
                  cp_resp = (word_i < c_inc) ? 3'd4 : 3'd5;
                  word_i++;
               end else begin
                  if (c_kind == 2)
                     chk(cp_wdata_o == c_wdata, "R9 move-to data", cp_wdata_o, c_wdata);
                  cp_resp = 3'd1;
               end
            end
            default: ;
         endcase
      end
      cp_rdata_i = (c_kind == 1) ? (c_stpat ^ 32'(word_i)) : c_from;
   end

   task automatic run_op(input int k, input int b, input int fin, input int irqa,
                         input int inc, input int abt, input logic [31:0] a, input bit mid);
      int exp_out, exp_pos, exp_words, pos, got;
      bit bad;
      logic [3:0] num;
      logic [31:0] prev_r;
      @(negedge clk);
      c_kind = k; c_busy = b; c_final = fin; c_irq = irqa; c_inc = inc; c_abort = abt;
      c_addr = a; c_wdata = $urandom; c_from = $urandom | 32'hF000_0000; c_stpat = $urandom;
      busy_given = 0; word_i = 0; ab = 0; irq = 1'b0;
      cp_rdata_i = (k == 1) ? c_stpat : c_from;
      num = 4'($urandom);
      instr_i = {20'($urandom), num, 8'($urandom)};
      kind_i = 3'(k); addr_i = a; wdata_i = c_wdata; start_i = 1'b1;
      prev_r = rdata_o;
      // expected outcome: 0 done, 1 undef, 2 abort, 3 interrupted
      bad = (k <= 1) && ((a >= 32'h0400_0000) || (k == 1 && a < 32'h20));
      exp_words = 0;
      if (bad) begin exp_out = 2; exp_pos = 0; end
      else if (irqa > 0 && irqa <= b) begin exp_out = 3; exp_pos = 2 * irqa; end
      else if (fin == 3) begin exp_out = 1; exp_pos = 2 * b + 1; end
      else if (k == 4 || k > 4) begin exp_out = 0; exp_pos = 2 * b + 1; end
      else if (k == 2) begin exp_out = 0; exp_pos = 2 * b + 2; end
      else if (k == 3) begin exp_out = 0; exp_pos = 2 * b + 3; end
      else if (abt >= 0 && abt <= inc) begin exp_out = 2; exp_pos = 2 * b + 2 + abt; exp_words = abt + 1; end
      else begin exp_out = 0; exp_pos = 2 * b + 2 + inc; exp_words = inc + 1; end
      @(negedge clk);
      start_i = 1'b0;
      pos = 0;
      if (!bad) begin
         chk(cp_phase_o == 3'd1, "R2 first phase offered", 32'(cp_phase_o), 1);
         chk(cp_num_o == num && cp_instr_o == instr_i, "R2 coprocessor number", 32'(cp_num_o), 32'(num));
      end
      while (!(done_o || undef_o || abort_o || intr_o) && pos < 100) begin
         @(negedge clk);
         pos++;
         if (mid && pos == 1) begin start_i = 1'b1; kind_i = 3'd4; end
         if (mid && pos == 2) start_i = 1'b0;
      end
      got = done_o ? 0 : undef_o ? 1 : abort_o ? 2 : intr_o ? 3 : 7;
      chk(got == exp_out, mid ? "R12 outcome with start while busy" :
          (exp_out == 3 ? "R4 interrupted" : exp_out == 1 ? "R5 undefined request" :
           (exp_out == 2 && exp_words == 0) ? "R7 address abort" : exp_out == 2 ? "R8 memory abort" : "R10 completion"),
          32'(got), 32'(exp_out));
      chk(pos == exp_pos, "R11 outcome cycle", 32'(pos), 32'(exp_pos));
      chk(word_i == exp_words, "R8 words transferred", 32'(word_i), 32'(exp_words));
      if (exp_out == 3) chk(cp_phase_o == 3'd3, "R4 interrupt phase", 32'(cp_phase_o), 3);
      if (k == 3 && exp_out == 0) chk(rdata_o == c_from, "R10 move-from result", rdata_o, c_from);
      if (k == 3 && exp_out == 1) chk(rdata_o == 0, "R5 refused move-from flags clear", rdata_o, 0);
      if (k == 3 && exp_out >= 2) chk(rdata_o == prev_r, "R4 result untouched", rdata_o, prev_r);
      @(negedge clk);
      chk(!(done_o || undef_o || abort_o || intr_o || busy_o), "R11 single-cycle pulse then idle",
          {27'd0, busy_o, intr_o, abort_o, undef_o, done_o}, 0);
      irq = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 32'hA500_0000 ^ (32'(i) * 32'h0101_0101);
      c_kind = 4; c_busy = 0; c_final = 1; c_irq = 0; c_inc = 0; c_abort = -1;
      c_addr = 0; c_wdata = 0; c_from = 0; c_stpat = 0;
      busy_given = 0; word_i = 0; ab = 0;
      void'($urandom(32'd7321));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cp_phase_o == 0 && !busy_o && !(done_o || undef_o || abort_o || intr_o),
          "R1 reset state", {26'd0, cp_phase_o, busy_o, done_o, abort_o}, 0);
      // directed corners
      run_op(4, 0, 1, 0, 0, -1, 32'h100, 0);          // R10 data op
      run_op(4, 3, 1, 0, 0, -1, 32'h100, 0);          // R3 busy loop
      run_op(0, 0, 1, 0, 3, -1, 32'h104, 0);          // R6 load 4 words
      run_op(1, 1, 1, 0, 2, -1, 32'h110, 0);          // R6 store 3 words
      run_op(0, 0, 1, 0, 2, -1, 32'h110, 0);          // R6 read back stored words
      run_op(2, 2, 1, 0, 0, -1, 32'h100, 0);          // R9 move to
      run_op(3, 0, 1, 0, 0, -1, 32'h100, 0);          // R10 move from
      run_op(3, 1, 3, 0, 0, -1, 32'h100, 0);          // R5 refused move from
      run_op(4, 0, 3, 0, 0, -1, 32'h100, 0);          // R5 refused data op
      run_op(4, 3, 1, 2, 0, -1, 32'h100, 0);          // R4 interrupt in loop
      run_op(0, 0, 1, 0, 0, -1, 32'h0400_0000, 0);    // R7 above limit
      run_op(1, 0, 1, 0, 0, -1, 32'h0000_0010, 0);    // R7 store into vectors
      run_op(0, 0, 1, 0, 0, -1, 32'h0000_0010, 0);    // R7 load from vectors legal
      run_op(1, 0, 1, 0, 0, -1, 32'h0000_0020, 0);    // R7 store at vector top legal
      run_op(0, 1, 1, 0, 3, 1, 32'h100, 0);           // R8 abort on second word
      run_op(0, 1, 1, 0, 2, -1, 32'h108, 1);          // R12 start while busy
      // constrained random
      for (int n = 0; n < 60; n++) begin
         int k, b, fin, ia, inc, abt;
         k   = int'($urandom % 5);
         b   = int'($urandom % 4);
         fin = ($urandom % 6 == 0) ? 3 : 1;
         ia  = (b > 0 && $urandom % 4 == 0) ? 1 + int'($urandom % b) : 0;
         inc = int'($urandom % 4);
         abt = ($urandom % 5 == 0) ? int'($urandom % (inc + 1)) : -1;
         run_op(k, b, fin, ia, inc, abt, 32'h100 + 32'(4 * ($urandom % 8)), 0);
      end
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule